// File: doc/BRIEF.md
# Keyed Flash Program/Erase Controller

This block is the register front end of an embedded flash array. A bus master loads a byte address and a data word into two registers. It then writes a command word whose upper half must carry a fixed key. One accepted command starts one operation: program a word, erase a page, erase a large span, or commit the program-enable mask. The array itself is modelled as on-chip storage. Program clears bits only (bitwise AND). Erase returns words to all ones.

Each pair of pages is a lock region with one program-enable bit, active low. Bits can be cleared freely, but once a mask is committed, no committed zero can be raised again. A program or erase aimed at a locked region, or at an address beyond the array, is refused. The refusal sets a sticky violation flag. Completion sets a second flag. Both flags have a mask and a write-one-to-clear register, and a single interrupt output is driven from them.

Operation time is counted in microsecond ticks. The tick comes from a reload register that software loads with the clock frequency in MHz minus one.

Top module: `kflash_ctl`

## Requirements
- R1: Register byte offsets: address 0x00, data 0x04, command 0x08, raw status 0x0C, interrupt mask 0x10, clear/masked status 0x14, program-enable mask 0x18, tick reload 0x1C, array window 0x20. The array window returns the array word at the address register, or 0 when that address is out of range. The address and data registers read back what was written.
- R2: A command write is accepted only when bits 31:16 equal 0xA442 and exactly one of bits 3:0 is set. Bit 0 is program, bit 1 is page erase, bit 2 is span erase and bit 3 is commit. Any other command write is ignored and leaves the array unchanged.
- R3: The command register reads the accepted command's bit as 1 while the operation runs, and reads 0 once it completes. A command write that arrives while busy is ignored.
- R4: After PROG_US ticks, a program replaces the addressed word with the old word AND the data register value.
- R5: A page erase sets all 256 words of the 1024-byte page that holds the address to 0xFFFFFFFF and changes no other word.
- R6: A span erase sets to 0xFFFFFFFF every page from the page holding the address up to 128 pages on, clipped to the array. A start at or beyond the array end completes and changes nothing.
- R7: Mask bit r (reset value 1) enables region r, which is pages 2r and 2r+1. A mask write takes the written value AND the committed mask. A commit with the address register equal to 1 copies the mask into the committed mask. A commit with any other address changes nothing.
- R8: A program or page erase whose region is disabled or whose address is beyond the array, or a span erase that overlaps a disabled region, is refused. The array is unchanged and the command bit never reads 1. Raw status bit 0 is set and stays set until a 1 is written to bit 0 of offset 0x14.
- R9: Raw status bit 1 is set when an operation completes, and is cleared by writing 1 to bit 1 of offset 0x14.
- R10: One tick occurs every reload+1 clock cycles. A program therefore stays busy for between 19*(reload+1)+1 and 20*(reload+1) cycles.
- R11: irq is high exactly when some raw status bit is set and its mask bit at offset 0x10 is 1. Offset 0x14 reads raw status AND mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Masked status interrupt |

## Verification
Word programs use random addresses and random data over the whole array. Repeated programs of the same word show AND accumulation rather than overwrite. Erases are tried with a page-start address, a mid-page address, a span starting at page 0 and a mid-array span. A span starting beyond the array shows the clipping and tells the page rule apart from the span rule.

Refusal cases cover a wrong key, two command bits at once, a command issued while busy, a locked region, an out-of-range address and a span crossing a lock. For each, the bench compares the untouched words and the flags. Busy time is measured at two reload values to show that the tick reload really sets the duration.

// File: rtl/kfc_pkg.sv
package kfc_pkg;

  localparam logic [15:0] CMD_KEY = 16'hA442;

  localparam logic [7:0] OFF_ADDR = 8'h00;
  localparam logic [7:0] OFF_DATA = 8'h04;
  localparam logic [7:0] OFF_CMD  = 8'h08;
  localparam logic [7:0] OFF_RAW  = 8'h0C;
  localparam logic [7:0] OFF_MASK = 8'h10;
  localparam logic [7:0] OFF_CLR  = 8'h14;
  localparam logic [7:0] OFF_PROT = 8'h18;
  localparam logic [7:0] OFF_USEC = 8'h1C;
  localparam logic [7:0] OFF_PEEK = 8'h20;

  typedef enum logic [1:0] {OP_PROG, OP_PERASE, OP_MERASE, OP_COMMIT} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SWEEP} st_e;

  // key in the upper half and exactly one request bit
  function automatic logic key_ok(input logic [31:0] w);
    return (w[31:16] == CMD_KEY) && $onehot(w[3:0]);
  endfunction

  function automatic op_e decode_op(input logic [3:0] b);
    if (b[1])      return OP_PERASE;
    else if (b[2]) return OP_MERASE;
    else if (b[3]) return OP_COMMIT;
    else           return OP_PROG;
  endfunction

  // a span of pages [first, first+span) touches a disabled two-page region
  function automatic logic span_locked(input logic [31:0] en, input int nreg,
                                       input int first, input int span);
    logic hit;
    hit = 1'b0;
    for (int r = 0; r < 32; r++) begin
      if (r < nreg && !en[r] && (2*r + 1 >= first) && (2*r < first + span))
        hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/kfc_array.sv
module kfc_array #(
  parameter int WORDS = 2048,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] ra0,
  output logic [31:0]   rd0,
  input  logic [AW-1:0] ra1,
  output logic [31:0]   rd1
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/kfc_usec.sv
module kfc_usec #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= reload;
    else           cnt_q <= cnt_q - 1'b1;
  end

  // R10: after a tick the countdown restarts from the reload value
  p_tick_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(reload)));
endmodule

// File: rtl/kfc_prot.sv
module kfc_prot #(
  parameter int NREG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NREG-1:0] wr_val,
  input  logic            commit_go,
  output logic [NREG-1:0] live,
  output logic [NREG-1:0] committed
);
  logic [NREG-1:0] live_q, com_q, com_next;

  assign com_next  = commit_go ? live_q : com_q;
  assign live      = live_q;
  assign committed = com_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '1;
      com_q  <= '1;
    end else begin
      com_q <= com_next;
      if (wr_en) live_q <= wr_val & com_next;
    end
  end

  // R7: a committed zero never returns to one
  p_commit_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((com_q & ~$past(com_q)) == '0));
  // R7: the working mask never enables what the committed mask locks
  p_live_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q & ~com_q) == '0);
endmodule

// File: rtl/kflash_ctl.sv
module kflash_ctl
  import kfc_pkg::*;
#(
  parameter int WORDS      = 2048,
  parameter int PAGE_BYTES = 1024,
  parameter int MASS_BYTES = 131072,
  parameter int PROG_US    = 20,
  parameter int ERASE_US   = 4,
  parameter int US_W       = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int NPAGES     = WORDS / PAGE_WORDS;
  localparam int NREG       = NPAGES / 2;
  localparam int AW         = $clog2(WORDS);
  localparam int PSHIFT     = $clog2(PAGE_BYTES);
  localparam int PWSHIFT    = PSHIFT - 2;
  localparam int MASS_PAGES = MASS_BYTES / PAGE_BYTES;

  logic [31:0]     fa_q, fd_q;
  logic [1:0]      raw_q, mask_q;
  logic [US_W-1:0] usec_q;
  st_e             st_q;
  op_e             op_q, req_op;
  logic [AW-1:0]   op_word_q;
  logic [31:0]     op_data_q;
  logic [15:0]     us_left_q;
  logic [AW:0]     sw_idx_q, sw_end_q, start_w, end_w;
  logic            op_key1_q;
  logic            tick;
  logic [NREG-1:0] prot_live, prot_com;
  logic [31:0]     prot_ext, peek_rd, op_rd;

  // named events
  logic wr_any, cmd_wr, busy, cmd_ok, in_range, region_open, mass_hit;
  logic viol_now, accept, wait_last, sweep_last, done_now, commit_go;
  logic mem_we;
  logic [AW-1:0] mem_waddr;
  logic [31:0]   mem_wdata;
  logic [1:0]    clr_bits;
  logic [4:0]    reg_idx;
  int            first_page;

  assign wr_any   = bus_sel && bus_wr;
  assign cmd_wr   = wr_any && (bus_addr == OFF_CMD);
  assign busy     = (st_q != ST_IDLE);
  assign cmd_ok   = cmd_wr && key_ok(bus_wdata) && !busy;
  assign req_op   = decode_op(bus_wdata[3:0]);
  assign in_range = (fa_q[31:2] < 30'(WORDS));
  assign reg_idx  = fa_q[PSHIFT+5:PSHIFT+1];
  assign prot_ext = 32'(prot_live);
  assign region_open = in_range && prot_ext[reg_idx];
  assign first_page  = int'(fa_q >> PSHIFT);
  assign mass_hit    = span_locked(prot_ext, NREG, first_page, MASS_PAGES);

  always_comb begin
    viol_now = 1'b0;
    if (cmd_ok) begin
      unique case (req_op)
        OP_PROG, OP_PERASE: viol_now = !region_open;
        OP_MERASE:          viol_now = mass_hit;
        default:            viol_now = 1'b0;
      endcase
    end
  end
  assign accept = cmd_ok && !viol_now;

  // word range an erase sweeps
  always_comb begin
    start_w = '0;
    end_w   = '0;
    if (req_op == OP_PERASE) begin
      start_w = (AW+1)'((fa_q[31:2] >> PWSHIFT) << PWSHIFT);
      end_w   = start_w + (AW+1)'(PAGE_WORDS);
    end else if (req_op == OP_MERASE && first_page < NPAGES) begin
      start_w = (AW+1)'(first_page * PAGE_WORDS);
      end_w   = (AW+1)'(((first_page + MASS_PAGES > NPAGES) ? NPAGES
                          : first_page + MASS_PAGES) * PAGE_WORDS);
    end
  end

  assign wait_last  = (st_q == ST_WAIT) && tick && (us_left_q == 16'd1);
  assign sweep_last = (st_q == ST_SWEEP) && (sw_idx_q + 1'b1 == sw_end_q);
  assign done_now   = (wait_last && (op_q == OP_PROG || op_q == OP_COMMIT ||
                                     sw_idx_q == sw_end_q)) || sweep_last;
  assign commit_go  = wait_last && (op_q == OP_COMMIT) && op_key1_q;

  assign mem_we    = (wait_last && op_q == OP_PROG) || (st_q == ST_SWEEP);
  assign mem_waddr = (st_q == ST_SWEEP) ? sw_idx_q[AW-1:0] : op_word_q;
  assign mem_wdata = (st_q == ST_SWEEP) ? 32'hFFFF_FFFF : (op_rd & op_data_q);

  kfc_array #(.WORDS(WORDS), .AW(AW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .ra0(fa_q[AW+1:2]), .rd0(peek_rd), .ra1(op_word_q), .rd1(op_rd));

  kfc_usec #(.W(US_W)) u_usec (
    .clk(clk), .rst_n(rst_n), .reload(usec_q), .tick(tick));

  kfc_prot #(.NREG(NREG)) u_prot (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_any && bus_addr == OFF_PROT), .wr_val(bus_wdata[NREG-1:0]),
    .commit_go(commit_go), .live(prot_live), .committed(prot_com));

  // operation sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_PROG;
      op_word_q <= '0;
      op_data_q <= '0;
      us_left_q <= '0;
      sw_idx_q  <= '0;
      sw_end_q  <= '0;
      op_key1_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q      <= ST_WAIT;
          op_q      <= req_op;
          op_word_q <= fa_q[AW+1:2];
          op_data_q <= fd_q;
          op_key1_q <= (fa_q == 32'd1);
          us_left_q <= (req_op == OP_PERASE || req_op == OP_MERASE)
                       ? 16'(ERASE_US) : 16'(PROG_US);
          sw_idx_q  <= start_w;
          sw_end_q  <= end_w;
        end
        ST_WAIT: if (tick) begin
          if (us_left_q == 16'd1) begin
            if ((op_q == OP_PERASE || op_q == OP_MERASE) && sw_idx_q != sw_end_q)
              st_q <= ST_SWEEP;
            else
              st_q <= ST_IDLE;
          end else begin
            us_left_q <= us_left_q - 1'b1;
          end
        end
        ST_SWEEP: begin
          sw_idx_q <= sw_idx_q + 1'b1;
          if (sweep_last) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // register file
  assign clr_bits = (wr_any && bus_addr == OFF_CLR) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fa_q   <= '0;
      fd_q   <= '0;
      mask_q <= '0;
      usec_q <= '0;
      raw_q  <= '0;
    end else begin
      if (wr_any && bus_addr == OFF_ADDR) fa_q   <= bus_wdata;
      if (wr_any && bus_addr == OFF_DATA) fd_q   <= bus_wdata;
      if (wr_any && bus_addr == OFF_MASK) mask_q <= bus_wdata[1:0];
      if (wr_any && bus_addr == OFF_USEC) usec_q <= bus_wdata[US_W-1:0];
      raw_q <= (raw_q & ~clr_bits) | {done_now, viol_now};
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFF_ADDR: bus_rdata = fa_q;
      OFF_DATA: bus_rdata = fd_q;
      OFF_CMD:  bus_rdata = busy ? (32'd1 << op_q) : 32'd0;
      OFF_RAW:  bus_rdata = {30'd0, raw_q};
      OFF_MASK: bus_rdata = {30'd0, mask_q};
      OFF_CLR:  bus_rdata = {30'd0, raw_q & mask_q};
      OFF_PROT: bus_rdata = prot_ext;
      OFF_USEC: bus_rdata = 32'(usec_q);
      OFF_PEEK: bus_rdata = in_range ? peek_rd : 32'd0;
      default:  bus_rdata = 32'd0;
    endcase
  end

  assign irq = |(raw_q & mask_q);

  // R3: a running operation only ends through its completion event
  p_busy_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_now) |=> busy);
  // R4: the array is written only while an operation runs
  p_no_idle_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R8: a refused command never starts an operation
  p_refused_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_now |=> !busy);
  // R8: the violation flag stays until cleared
  p_viol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q[0] && !clr_bits[0]) |=> raw_q[0]);
  // R11: a zero mask silences the interrupt
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 2'b00) |-> !irq);
endmodule

// File: tb/tb_kflash_ctl.sv
`timescale 1ns/1ps
module tb_kflash_ctl;
  localparam int WORDS = 2048;
  localparam int PW    = 256;
  localparam int NPG   = 8;
  localparam logic [31:0] KEY = 32'hA442_0000;

  logic        clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  kflash_ctl dut (.clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
                  .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  int n_chk = 0, n_bad = 0;
  logic [31:0] mdl [WORDS];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a; #1; d = rdata; sel = 0;
  endtask

  task automatic peek(input int idx, output logic [31:0] d);
    bw(8'h00, 32'(idx * 4)); br(8'h20, d);
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    do begin br(8'h08, v); cyc++; end while (v != 0 && cyc < 6000);
  endtask

  function automatic int region_of(input int word_idx);
    return word_idx / (2 * PW);
  endfunction

  function automatic logic [31:0] prog_val(input logic [31:0] old, input logic [31:0] d);
    return old & d;
  endfunction

  task automatic erase_pages(input int first, input int count);
    for (int p = first; p < first + count && p < NPG; p++)
      for (int w = 0; w < PW; w++) mdl[p*PW + w] = 32'hFFFF_FFFF;
  endtask

  task automatic do_prog(input int idx, input logic [31:0] d);
    int c;
    bw(8'h00, 32'(idx*4)); bw(8'h04, d); bw(8'h08, KEY | 32'h1); wait_idle(c);
  endtask

  task automatic verify_all(input string req);
    int mism; logic [31:0] v, a1, e1;
    mism = 0; a1 = 0; e1 = 0;
    for (int i = 0; i < WORDS; i++) begin
      peek(i, v);
      if (v !== mdl[i]) begin
        if (mism == 0) begin a1 = v; e1 = mdl[i]; end
        mism++;
      end
    end
    chk(mism == 0, req, a1, e1);
  endtask

  initial begin
    #(200000 * 5.0);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, d, old;
    int c, idx;
    int unsigned seed;
    seed = $urandom(1234);
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    br(8'h08, v); chk(v == 0, "R1 cmd reset", v, 0);
    br(8'h0C, v); chk(v == 0, "R1 raw reset", v, 0);
    br(8'h18, v); chk(v == 32'hF, "R7 mask reset", v, 32'hF);
    chk(irq == 0, "R11 irq reset", 32'(irq), 0);

    // R6: span erase from 0 covers the whole array
    bw(8'h00, 0); bw(8'h08, KEY | 32'h4); wait_idle(c);
    erase_pages(0, NPG);
    verify_all("R6 full span erase");
    br(8'h0C, v); chk(v == 2, "R9 done flag", v, 2);
    bw(8'h14, 2); br(8'h0C, v); chk(v == 0, "R9 done clear", v, 0);

    // R1: address and data readback
    d = $urandom; bw(8'h00, d); br(8'h00, v); chk(v == d, "R1 addr readback", v, d);
    d = $urandom; bw(8'h04, d); br(8'h04, v); chk(v == d, "R1 data readback", v, d);
    bw(8'h00, 32'h4000); br(8'h20, v); chk(v == 0, "R1 window out of range", v, 0);

    // R4: random programs, some repeated on the same word
    for (int k = 0; k < 40; k++) begin
      idx = (k % 5 == 4) ? 100 : int'($urandom % WORDS);
      d = $urandom;
      do_prog(idx, d);
      mdl[idx] = prog_val(mdl[idx], d);
      peek(idx, v);
      chk(v == mdl[idx], "R4 program AND", v, mdl[idx]);
    end

    // R2: wrong key and double bits are ignored
    idx = 300; peek(idx, old);
    bw(8'h04, 32'h0); bw(8'h08, 32'h1234_0001);
    br(8'h08, v); chk(v == 0, "R2 bad key no busy", v, 0);
    repeat (30) @(negedge clk);
    peek(idx, v); chk(v == old, "R2 bad key array", v, old);
    bw(8'h08, KEY | 32'h3);
    br(8'h08, v); chk(v == 0, "R2 two bits ignored", v, 0);
    repeat (30) @(negedge clk);
    peek(idx, v); chk(v == old, "R2 two bits array", v, old);

    // R3: busy readback and command while busy ignored
    bw(8'h00, 32'(400*4)); bw(8'h04, 32'h0F0F_0000); bw(8'h08, KEY | 32'h1);
    br(8'h08, v); chk(v == 1, "R3 busy bit", v, 1);
    bw(8'h00, 32'(401*4)); bw(8'h04, 32'h0); bw(8'h08, KEY | 32'h1);
    wait_idle(c);
    br(8'h08, v); chk(v == 0, "R3 self clear", v, 0);
    mdl[400] = prog_val(mdl[400], 32'h0F0F_0000);
    peek(400, v); chk(v == mdl[400], "R3 first op", v, mdl[400]);
    peek(401, v); chk(v == mdl[401], "R3 busy cmd ignored", v, mdl[401]);

    // R5: page erase from the first word and from mid page
    do_prog(3*PW - 1, 32'h0); mdl[3*PW-1] = 0;
    do_prog(4*PW, 32'h0);     mdl[4*PW] = 0;
    do_prog(3*PW + 7, 32'h0); mdl[3*PW+7] = 0;
    bw(8'h00, 32'(3*PW*4)); bw(8'h08, KEY | 32'h2); wait_idle(c);
    erase_pages(3, 1);
    peek(3*PW + 7, v); chk(v == 32'hFFFF_FFFF, "R5 page word erased", v, 32'hFFFF_FFFF);
    peek(3*PW - 1, v); chk(v == 0, "R5 prev page kept", v, 0);
    peek(4*PW, v); chk(v == 0, "R5 next page kept", v, 0);
    do_prog(5*PW + 9, 32'h0); mdl[5*PW+9] = 0;
    bw(8'h00, 32'(5*PW*4 + 600)); bw(8'h08, KEY | 32'h2); wait_idle(c);
    erase_pages(5, 1);
    verify_all("R5 mid page erase");
    bw(8'h14, 3);

    // R8: region 1 (pages 2,3) disabled
    bw(8'h18, 32'hD); br(8'h18, v); chk(v == 32'hD, "R7 mask write", v, 32'hD);
    idx = 2*PW + 5; peek(idx, old);
    bw(8'h04, 32'h0); bw(8'h08, KEY | 32'h1);
    br(8'h08, v); chk(v == 0, "R8 refused no busy", v, 0);
    br(8'h0C, v); chk(v == 1, "R8 violation flag", v, 1);
    peek(idx, v); chk(v == old, "R8 array kept", v, old);
    bw(8'h00, 32'(3*PW*4)); bw(8'h08, KEY | 32'h2); wait_idle(c);
    peek(3*PW, v); chk(v == mdl[3*PW], "R8 page erase refused", v, mdl[3*PW]);
    bw(8'h00, 0); bw(8'h08, KEY | 32'h4); wait_idle(c);
    peek(4*PW, v); chk(v == 0, "R8 span erase refused", v, 0);
    repeat (20) @(negedge clk);
    br(8'h0C, v); chk(v[0] == 1, "R8 flag sticky", v, 1);
    // R11: masking
    bw(8'h10, 1); chk(irq == 1, "R11 irq on", 32'(irq), 1);
    br(8'h14, v); chk(v == 1, "R11 masked read", v, 1);
    bw(8'h10, 2); chk(irq == 0, "R11 irq masked off", 32'(irq), 0);
    bw(8'h14, 1); br(8'h0C, v); chk(v == 0, "R8 flag clear", v, 0);
    bw(8'h10, 0);
    do_prog(10, 32'h1234_5678); mdl[10] = prog_val(mdl[10], 32'h1234_5678);
    peek(10, v); chk(v == mdl[10], "R8 open region programs", v, mdl[10]);
    bw(8'h00, 32'h4000); bw(8'h08, KEY | 32'h1);
    br(8'h0C, v); chk(v[0] == 1, "R8 out of range", v, 1);
    bw(8'h14, 3);

    // R7: commit rules
    bw(8'h00, 0); bw(8'h08, KEY | 32'h8); wait_idle(c);
    bw(8'h18, 32'hF); br(8'h18, v); chk(v == 32'hF, "R7 commit wrong addr", v, 32'hF);
    bw(8'h18, 32'hD); bw(8'h00, 1); bw(8'h08, KEY | 32'h8); wait_idle(c);
    bw(8'h18, 32'hF); br(8'h18, v); chk(v == 32'hD, "R7 committed zero", v, 32'hD);
    bw(8'h18, 32'h5); br(8'h18, v); chk(v == 32'h5, "R7 clear after commit", v, 32'h5);
    bw(8'h18, 32'hF); br(8'h18, v); chk(v == 32'hD, "R7 restore limit", v, 32'hD);

    // R6: span beyond array, then mid-array span
    bw(8'h14, 3);
    bw(8'h00, 32'h20000); bw(8'h08, KEY | 32'h4); wait_idle(c);
    br(8'h0C, v); chk(v == 2, "R6 empty span completes", v, 2);
    do_prog(6*PW, 32'h0); mdl[6*PW] = 0;
    bw(8'h00, 32'h1000); bw(8'h08, KEY | 32'h4); wait_idle(c);
    erase_pages(4, 128);
    verify_all("R6 span from page 4");

    // R10: tick reload sets busy time
    bw(8'h1C, 3); bw(8'h00, 32'(20*4)); bw(8'h04, 32'hFFFF_0000); bw(8'h08, KEY | 32'h1);
    wait_idle(c); chk(c >= 75 && c <= 82, "R10 reload 3", 32'(c), 80);
    bw(8'h1C, 7); bw(8'h08, KEY | 32'h1);
    wait_idle(c); chk(c >= 150 && c <= 162, "R10 reload 7", 32'(c), 160);
    br(8'h1C, v); chk(v == 7, "R1 reload readback", v, 7);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule